// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter, four bits wide by default, whose flops all change together on the rising edge of `clock`. A low level on `zero_n` empties it at once, with no clock needed. A low level on `preset_n` makes the next edge copy `din` into the count. Two count enables control stepping. `cnt_en` is meant to be shared by every stage of a wider counter. `chain_en` is the carry input from the stage below.

`carry_out` is combinational. It rises while the count sits at its all-ones value and `chain_en` is high. Wiring each stage's `carry_out` to the next stage's `chain_en`, with `cnt_en` and `clock` common to all stages, builds a wider counter that steps as one binary number and needs no extra gating.

Top module: `presettable_counter`

## Requirements
- R1: `count` changes only on a rising edge of `clock` or through `zero_n`; changes of `preset_n`, `cnt_en`, `chain_en` or `din` between edges leave `count` unchanged until the next rising edge.
- R2: While `zero_n` is low, `count` is 0 immediately (asynchronously), whatever `clock`, `preset_n`, `cnt_en`, `chain_en` and `din` do.
- R3: With `zero_n` high and `preset_n` low, the next rising edge loads `din` into `count`, whatever `cnt_en` and `chain_en` are.
- R4: With `zero_n` and `preset_n` high and both `cnt_en` and `chain_en` high, each rising edge adds one to `count`; the all-ones value (15 at WIDTH 4) wraps to 0.
- R5: With `zero_n` and `preset_n` high and `cnt_en` or `chain_en` low, a rising edge leaves `count` unchanged.
- R6: `carry_out` is 1 exactly when `count` is all ones and `chain_en` is 1. It follows `chain_en` with no clock edge, it does not depend on `cnt_en`, and it falls as soon as `count` leaves all ones.
- R7: When stages are chained, each stage's `carry_out` drives the next stage's `chain_en`, and all stages share `cnt_en`, `preset_n`, `zero_n` and `clock`. The chained counts then step as one binary number: stage k holds bits 4k+3..4k, the upper stages advance on the lower stage's wrap, and the top `carry_out` is 1 at the all-ones total.
- R8: The sequence runs clear to 0, preset to 12, then counts 13, 14, 15, 0, 1, 2, then inhibit. `carry_out` is high only while `count` is 15, and the value 2 holds once either enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clock | input | 1 | Rising-edge clock |
| zero_n | input | 1 | Asynchronous active-low clear of the count |
| preset_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable shared by all chained stages |
| chain_en | input | 1 | Count enable that also gates `carry_out` |
| din | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count carry to the next stage |

## Verification
Load, step and hold results are due one rising edge after the inputs are set. The bench changes inputs on the falling edge, advances its behavioural model at the rising edge, and compares 2 ns later. `carry_out` and the clear are due with no edge at all, so the bench checks them 1 ns after driving the input, in the middle of the cycle. The bench also changes the synchronous controls between edges to confirm that nothing moves until the next edge. All sixteen combinations of the four controls are applied from starting values of both 14 and 15, and a three-stage chain is compared against a 12-bit model across wraps between stages.

// File: rtl/ctr_pkg.sv
// Shared types for the presettable counter.
// Assumes: a single clock domain; the op encoding is internal only.
package ctr_pkg;
    // Action the counter takes at the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } ctr_op_e;
endpackage

// File: rtl/ctr_mode_decode.sv
// Priority decode of the synchronous controls into one action.
// Load outranks both enables; stepping needs both enables.
// Assumes: the asynchronous clear is handled at the register, not here.
module ctr_mode_decode
    import ctr_pkg::*;
(
    input  logic    preset_n,
    input  logic    cnt_en,
    input  logic    chain_en,
    output ctr_op_e op
);
    // Choose the action for the coming edge.
    always_comb begin
        if (!preset_n)                op = OP_LOAD;
        else if (cnt_en && chain_en)  op = OP_STEP;
        else                          op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_next.sv
// Next-count logic: a look-ahead toggle chain for the increment
// and a selector for hold, step or load.
// Assumes: WIDTH >= 1; wrap from all ones to zero is natural overflow.
module ctr_next
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  ctr_op_e          op,
    output logic [WIDTH-1:0] nxt
);
    logic [WIDTH-1:0] toggle;
    logic [WIDTH-1:0] stepped;

    // Bit i toggles when every lower bit is one.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign toggle[i] = 1'b1;
        end else begin : g_upper
            assign toggle[i] = toggle[i-1] & cur[i-1];
        end
        assign stepped[i] = cur[i] ^ toggle[i];
    end

    // Pick the value to register.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_STEP: nxt = stepped;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_carry.sv
// Terminal-count detect: carry is high at all ones, gated only by chain_en.
// Assumes: purely combinational, so it tracks chain_en without a clock.
module ctr_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             chain_en,
    output logic             carry_out
);
    // Flag the all-ones count when the carry input is enabled.
    always_comb carry_out = chain_en & (&count);
endmodule

// File: rtl/presettable_counter.sv
// Presettable synchronous up-counter with an asynchronous active-low clear
// and a ripple carry for chaining stages.
// Assumes: one clock; zero_n may change at any time; other inputs are
// sampled at the rising edge.
module presettable_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clock,
    input  logic             zero_n,
    input  logic             preset_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctr_op_e          op;
    logic [WIDTH-1:0] nxt;

    ctr_mode_decode u_decode (
        .preset_n (preset_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .op       (op)
    );

    ctr_next #(.WIDTH(WIDTH)) u_next (
        .cur (count),
        .din (din),
        .op  (op),
        .nxt (nxt)
    );

    ctr_carry #(.WIDTH(WIDTH)) u_carry (
        .count     (count),
        .chain_en  (chain_en),
        .carry_out (carry_out)
    );

    // Count register; the clear acts without waiting for the clock.
    always_ff @(posedge clock or negedge zero_n) begin
        if (!zero_n) count <= '0;
        else         count <= nxt;
    end

    // R2: a held clear keeps the count at zero.
    assert_clear_zero_R2: assert property (@(posedge clock)
        !zero_n |-> count == '0);

    // R3: a load copies din regardless of enables.
    assert_load_din_R3: assert property (@(posedge clock) disable iff (!zero_n)
        !preset_n |=> count == $past(din));

    // R4: both enables step the count by one, wrapping.
    assert_step_one_R4: assert property (@(posedge clock) disable iff (!zero_n)
        (preset_n && cnt_en && chain_en) |=> count == WIDTH'($past(count) + 1'b1));

    // R5: a missing enable holds the count.
    assert_hold_R5: assert property (@(posedge clock) disable iff (!zero_n)
        (preset_n && !(cnt_en && chain_en)) |=> $stable(count));

    // R6: carry only with chain_en high and the count at all ones.
    assert_carry_gate_R6: assert property (@(posedge clock) disable iff (!zero_n)
        carry_out |-> (chain_en && count == ALL_ONES));
endmodule

// File: tb/test_presettable_counter.sv
// Three counter stages chained through their carries (R7 wrapper).
module test_chain #(
    parameter int STAGES = 3,
    parameter int W      = 4
) (
    input  logic              clock,
    input  logic              zero_n,
    input  logic              preset_n,
    input  logic              cnt_en,
    input  logic              top_en,
    input  logic [STAGES*W-1:0] din,
    output logic [STAGES*W-1:0] value,
    output logic              carry
);
    logic [STAGES:0] link;
    assign link[0] = top_en;
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        presettable_counter #(.WIDTH(W)) u_stage (
            .clock     (clock),
            .zero_n    (zero_n),
            .preset_n  (preset_n),
            .cnt_en    (cnt_en),
            .chain_en  (link[k]),
            .din       (din[k*W +: W]),
            .count     (value[k*W +: W]),
            .carry_out (link[k+1])
        );
    end
    assign carry = link[STAGES];
endmodule

module test_presettable_counter;
    logic       clock = 1'b0;
    logic       zero_n = 1'b0;
    logic       preset_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       chain_en = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] count;
    logic       carry_out;

    logic        ch_preset_n = 1'b1;
    logic        ch_cnt_en = 1'b0;
    logic        ch_top_en = 1'b0;
    logic [11:0] ch_din = 12'd0;
    logic [11:0] ch_value;
    logic        ch_carry;

    int n_checks = 0;
    int n_fails = 0;
    int mq = 0;
    int cm = 0;
    bit done = 0;

    always #5 clock = ~clock;

    presettable_counter #(.WIDTH(4)) i_presettable_counter (
        .clock(clock), .zero_n(zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .count(count), .carry_out(carry_out)
    );

    test_chain #(.STAGES(3), .W(4)) u_chain (
        .clock(clock), .zero_n(zero_n), .preset_n(ch_preset_n), .cnt_en(ch_cnt_en),
        .top_en(ch_top_en), .din(ch_din), .value(ch_value), .carry(ch_carry)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance both models at a rising edge, then compare 2 ns later.
    task automatic step(input string req);
        @(posedge clock);
        if (!zero_n) mq = 0;
        else if (!preset_n) mq = int'(din);
        else if (cnt_en && chain_en) mq = (mq + 1) % 16;
        if (!zero_n) cm = 0;
        else if (!ch_preset_n) cm = int'(ch_din);
        else if (ch_cnt_en && ch_top_en) cm = (cm + 1) % 4096;
        #2;
        check(req, int'(count), mq);
        check("R6", int'(carry_out), (mq == 15 && chain_en) ? 1 : 0);
        check("R7", int'(ch_value), cm);
        check("R7", int'(ch_carry), (cm == 4095 && ch_top_en) ? 1 : 0);
    endtask

    task automatic preload(input int v);
        @(negedge clock);
        zero_n = 1'b1; preset_n = 1'b0; din = 4'(v);
        step("R3");
    endtask

    initial begin
        repeat (100000) @(posedge clock);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1;
        check("R2 reset", int'(count), 0);
        check("R6 reset", int'(carry_out), 0);
        step("R2");

        // R8 reference sequence with a mid-cycle clear first.
        preload(9);
        @(negedge clock); #1;
        zero_n = 1'b0; #1;
        mq = 0; cm = 0;
        check("R2 async", int'(count), 0);
        check("R2 async chain", int'(ch_value), 0);
        @(negedge clock);
        zero_n = 1'b1; preset_n = 1'b0; din = 4'd12; cnt_en = 1'b1; chain_en = 1'b1;
        step("R8");
        @(negedge clock); preset_n = 1'b1;
        for (int s = 0; s < 6; s++) step("R8");
        check("R8 end", int'(count), 2);
        @(negedge clock); cnt_en = 1'b0;
        step("R8"); step("R8");
        check("R8 inhibit", int'(count), 2);

        // R1: controls changed between edges move nothing.
        @(negedge clock); #1;
        preset_n = 1'b0; din = 4'd7; cnt_en = 1'b1; #1;
        check("R1", int'(count), 2);
        preset_n = 1'b1; #1;
        check("R1", int'(count), 2);
        step("R4");

        // R6: carry follows chain_en with no edge and ignores cnt_en.
        preload(15);
        @(negedge clock); cnt_en = 1'b0; chain_en = 1'b0; #1;
        check("R6 ent low", int'(carry_out), 0);
        chain_en = 1'b1; #1;
        check("R6 ent high", int'(carry_out), 1);
        step("R5");

        // All control combinations from 14 and 15.
        for (int st = 14; st <= 15; st++) begin
            for (int v = 0; v < 16; v++) begin
                string req;
                preload(st);
                @(negedge clock);
                zero_n = v[3]; preset_n = v[2]; cnt_en = v[1]; chain_en = v[0];
                din = 4'(v ^ 5);
                #1;
                if (!zero_n) begin
                    mq = 0; cm = 0;
                    check("R2 combo", int'(count), 0);
                end
                check("R6 combo", int'(carry_out), (mq == 15 && chain_en) ? 1 : 0);
                if (!zero_n) req = "R2";
                else if (!preset_n) req = "R3";
                else if (cnt_en && chain_en) req = "R4";
                else req = "R5";
                step(req);
            end
        end

        // R7: chained stages across inner and full wraps.
        @(negedge clock);
        zero_n = 1'b1; ch_preset_n = 1'b0; ch_din = 12'hFFD; ch_cnt_en = 1'b1; ch_top_en = 1'b1;
        step("R7");
        @(negedge clock); ch_preset_n = 1'b1;
        for (int s = 0; s < 5; s++) step("R7");
        @(negedge clock); ch_preset_n = 1'b0; ch_din = 12'h0FE;
        step("R7");
        @(negedge clock); ch_preset_n = 1'b1;
        for (int s = 0; s < 3; s++) step("R7");
        check("R7 ripple", int'(ch_value), 12'h101);
        @(negedge clock); ch_preset_n = 1'b0; ch_din = 12'hFFF;
        step("R7");
        @(negedge clock); ch_preset_n = 1'b1; ch_cnt_en = 1'b0;
        step("R7");
        check("R7 top carry", int'(ch_carry), 1);
        @(negedge clock); ch_top_en = 1'b0; #1;
        check("R7 carry gate", int'(ch_carry), 0);
        step("R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule